// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a processor and a group of devices that raise interrupt requests. Each device request line is resynchronized, and a separate non-maskable request is turned into a pending event on its rising edge. When the processor signals that it is about to begin a new instruction, the controller picks the most urgent request. That request must beat the level currently in service. The controller then announces the winner to all devices as a binary level code.

The acknowledged device answers with a vector number. The controller registers the handler-table address that the vector selects: a base address plus four bytes per vector. On the next cycle it hands that address to the processor with a one-cycle take pulse. The level that was in service before is saved on a small stack. A return strobe from the processor restores it, so nested handlers unwind in order and any lower request still waiting is served at the next boundary.

The control flow is a three-state machine. WAIT idles and arbitrates. ACK drives the level code and waits for the vector. TAKE issues the handler address. The transitions are: WAIT to ACK on a boundary with an eligible winner and no return in that cycle. ACK to TAKE when the vector is valid. TAKE to WAIT always. A return strobe is only honoured in WAIT.

Top module: `prio_vec_irq_ctrl`

## Requirements
- R1: When several device lines request in the same arbitration, the lowest-numbered line wins. Device line i is reported with level code i+1.
- R2: While ack_valid is high, ack_code holds the winning level code and stays stable until vec_valid is seen. The non-maskable request uses code 0.
- R3: A device request is accepted only if its level code is strictly lower (more urgent) than the level in service. With nothing in service the level is NUM_LINES+1, so any device line is accepted.
- R4: A pulse on irq_return in WAIT restores the previously saved level. A lower-priority request that was blocked and is still held is acknowledged at the next boundary.
- R5: A rising edge on nmi_req is always acknowledged with code 0, whatever level is in service, including another non-maskable handler.
- R6: Arbitration happens only in WAIT, and only in a cycle where insn_boundary is high. Without it, a held request is never acknowledged.
- R7: Each request input passes two synchronizing flops. A request first driven before clock edge k is arbitrated at edge k+2 at the earliest.
- R8: handler_addr equals table_base plus vec_in times 4, both sampled in the cycle where vec_valid is high during ACK.
- R9: take is high for exactly one cycle, the cycle after the vector is captured, and handler_addr is valid with it.
- R10: The save stack holds STK_DEPTH levels. A push onto a full stack discards the saved value and sets stk_ovf. A return with an empty stack sets stk_unf and leaves nothing in service. Both flags stay set until reset.
- R11: After reset, ack_valid, take, stk_ovf and stk_unf are 0 and nothing is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | NUM_LINES | Device request lines, bit 0 most urgent |
| nmi_req | input | 1 | Non-maskable request, edge sensitive |
| insn_boundary | input | 1 | Processor is at the start of an instruction |
| irq_return | input | 1 | Processor leaves the current handler |
| ack_valid | output | 1 | Acknowledge phase active |
| ack_code | output | LVL_W | Binary code of the acknowledged level |
| vec_valid | input | 1 | Device drives its vector number |
| vec_in | input | VEC_W | Vector number from the device |
| table_base | input | ADDR_W | Base address of the handler table |
| take | output | 1 | One-cycle pulse: jump through handler_addr |
| handler_addr | output | ADDR_W | Handler-table entry address |
| stk_ovf | output | 1 | Sticky save-stack overflow flag |
| stk_unf | output | 1 | Sticky save-stack underflow flag |

## Verification
Several properties are checked on every cycle:
- An acknowledge only starts after an instruction boundary.
- A device acknowledge always beats the level that was in service.
- The code stays steady until the vector arrives.
- take is a single-cycle pulse that follows a vector capture, and its address is the base plus four times the vector.

Some behaviours can only be shown by the bench's scenarios:
- Which line wins among all request combinations.
- Blocked requests being served after the return unwinds.
- The non-maskable request nesting on itself.
- The exact two-edge synchronizer latency.
- The overflow and underflow flags at the stack limits.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_ACK  = 2'd1,
        ST_TAKE = 2'd2
    } pvic_state_e;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    for (genvar b = 0; b < W; b++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1[b] <= 1'b0;
                q[b]      <= 1'b0;
            end else begin
                stage1[b] <= d[b];
                q[b]      <= stage1[b];
            end
        end
    end
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
    parameter int NUM_LINES = 4,
    parameter int LVL_W     = 3
) (
    input  logic [NUM_LINES-1:0] req,
    input  logic                 nmi_pend,
    input  logic [LVL_W-1:0]     cur_lvl,
    output logic                 win,
    output logic [LVL_W-1:0]     win_code
);
    localparam logic [LVL_W-1:0] NONE = LVL_W'(NUM_LINES + 1);

    logic [LVL_W-1:0] dev_code;
    logic             dev_ok;

    always_comb begin
        dev_code = NONE;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (req[i]) dev_code = LVL_W'(i + 1);
        end
        dev_ok   = (|req) && (dev_code < cur_lvl);
        win      = nmi_pend || dev_ok;
        win_code = nmi_pend ? '0 : dev_code;
    end
endmodule

// File: rtl/pvic_lvl_stack.sv
module pvic_lvl_stack #(
    parameter int DEPTH = 6,
    parameter int LVL_W = 3,
    parameter int IDLE  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LVL_W-1:0] push_lvl,
    input  logic             pop,
    output logic [LVL_W-1:0] cur_lvl,
    output logic             ovf,
    output logic             unf
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [LVL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            cur_lvl <= LVL_W'(IDLE);
            ovf     <= 1'b0;
            unf     <= 1'b0;
        end else if (push) begin
            if (cnt == CNT_W'(DEPTH)) begin
                ovf <= 1'b1;
            end else begin
                mem[IDX_W'(cnt)] <= cur_lvl;
                cnt              <= cnt + 1'b1;
            end
            cur_lvl <= push_lvl;
        end else if (pop) begin
            if (cnt == '0) begin
                unf     <= 1'b1;
                cur_lvl <= LVL_W'(IDLE);
            end else begin
                cur_lvl <= mem[IDX_W'(cnt - 1'b1)];
                cnt     <= cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/prio_vec_irq_ctrl.sv
module prio_vec_irq_ctrl
    import pvic_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int VEC_W     = 4,
    parameter int ADDR_W    = 16,
    parameter int STK_DEPTH = NUM_LINES + 2,
    localparam int LVL_W    = $clog2(NUM_LINES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_req,
    input  logic                 nmi_req,
    input  logic                 insn_boundary,
    input  logic                 irq_return,
    output logic                 ack_valid,
    output logic [LVL_W-1:0]     ack_code,
    input  logic                 vec_valid,
    input  logic [VEC_W-1:0]     vec_in,
    input  logic [ADDR_W-1:0]    table_base,
    output logic                 take,
    output logic [ADDR_W-1:0]    handler_addr,
    output logic                 stk_ovf,
    output logic                 stk_unf
);
    localparam int IDLE_LVL = NUM_LINES + 1;
    localparam int PAD_W    = ADDR_W - VEC_W - 2;

    pvic_state_e      state, nxt;
    logic [NUM_LINES:0] sync_q;
    logic             nmi_d, nmi_pend, nmi_rise;
    logic             win;
    logic [LVL_W-1:0] win_code, acked_code, cur_lvl;
    logic [ADDR_W-1:0] addr_q;
    logic             start_ack, capture, pop;

    pvic_sync #(.W(NUM_LINES + 1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({nmi_req, irq_req}), .q(sync_q)
    );

    pvic_arb #(.NUM_LINES(NUM_LINES), .LVL_W(LVL_W)) u_arb (
        .req(sync_q[NUM_LINES-1:0]), .nmi_pend(nmi_pend), .cur_lvl(cur_lvl),
        .win(win), .win_code(win_code)
    );

    pvic_lvl_stack #(.DEPTH(STK_DEPTH), .LVL_W(LVL_W), .IDLE(IDLE_LVL)) u_stk (
        .clk(clk), .rst_n(rst_n), .push(capture), .push_lvl(acked_code),
        .pop(pop), .cur_lvl(cur_lvl), .ovf(stk_ovf), .unf(stk_unf)
    );

    assign nmi_rise  = sync_q[NUM_LINES] && !nmi_d;
    assign start_ack = (state == ST_WAIT) && !irq_return && insn_boundary && win;
    assign capture   = (state == ST_ACK) && vec_valid;
    assign pop       = (state == ST_WAIT) && irq_return;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT: if (start_ack) nxt = ST_ACK;
            ST_ACK:  if (vec_valid) nxt = ST_TAKE;
            ST_TAKE: nxt = ST_WAIT;
            default: nxt = ST_WAIT;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_d      <= 1'b0;
            nmi_pend   <= 1'b0;
            acked_code <= '0;
            addr_q     <= '0;
        end else begin
            nmi_d <= sync_q[NUM_LINES];
            if (start_ack && win_code == '0) nmi_pend <= 1'b0;
            else if (nmi_rise)               nmi_pend <= 1'b1;
            if (start_ack) acked_code <= win_code;
            if (capture)   addr_q <= table_base + {{PAD_W{1'b0}}, vec_in, 2'b00};
        end
    end

    // outputs
    always_comb begin
        ack_valid    = (state == ST_ACK);
        take         = (state == ST_TAKE);
        ack_code     = acked_code;
        handler_addr = addr_q;
    end
endmodule

// File: rtl/pvic_checks.sv
module pvic_checks #(
    parameter int NUM_LINES = 4,
    parameter int VEC_W     = 4,
    parameter int ADDR_W    = 16,
    parameter int LVL_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              insn_boundary,
    input logic              ack_valid,
    input logic [LVL_W-1:0]  ack_code,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_in,
    input logic [ADDR_W-1:0] table_base,
    input logic              take,
    input logic [ADDR_W-1:0] handler_addr,
    input logic [LVL_W-1:0]  cur_lvl
);
    localparam int PAD_W = ADDR_W - VEC_W - 2;

    a_r2_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> ack_code <= LVL_W'(NUM_LINES));

    a_r2_code_held: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !vec_valid) |=> (ack_valid && $stable(ack_code)));

    a_r3_beats_level: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ack_valid) && ack_code != '0) |-> (ack_code < $past(cur_lvl)));

    a_r6_needs_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_valid) |-> $past(insn_boundary));

    a_r8_addr_value: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> handler_addr == $past(table_base) + {{PAD_W{1'b0}}, $past(vec_in), 2'b00});

    a_r9_take_after_vec: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> $past(ack_valid && vec_valid));

    a_r9_take_single: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take);
endmodule

bind prio_vec_irq_ctrl pvic_checks #(
    .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .insn_boundary(insn_boundary),
    .ack_valid(ack_valid), .ack_code(ack_code), .vec_valid(vec_valid),
    .vec_in(vec_in), .table_base(table_base), .take(take),
    .handler_addr(handler_addr), .cur_lvl(cur_lvl)
);

// File: tb/sim_prio_vec_irq_ctrl.sv
module sim_prio_vec_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N   = 4;
    localparam int VW  = 4;
    localparam int AW  = 16;
    localparam int LW  = 3;
    localparam int DEP = N + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_req = '0;
    logic          nmi_req = 1'b0;
    logic          insn_boundary = 1'b0;
    logic          irq_return = 1'b0;
    logic          ack_valid;
    logic [LW-1:0] ack_code;
    logic          vec_valid = 1'b0;
    logic [VW-1:0] vec_in = '0;
    logic [AW-1:0] table_base = 16'h4000;
    logic          take;
    logic [AW-1:0] handler_addr;
    logic          stk_ovf, stk_unf;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    prio_vec_irq_ctrl #(.NUM_LINES(N), .VEC_W(VW), .ADDR_W(AW), .STK_DEPTH(DEP)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .nmi_req(nmi_req),
        .insn_boundary(insn_boundary), .irq_return(irq_return),
        .ack_valid(ack_valid), .ack_code(ack_code), .vec_valid(vec_valid),
        .vec_in(vec_in), .table_base(table_base), .take(take),
        .handler_addr(handler_addr), .stk_ovf(stk_ovf), .stk_unf(stk_unf)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    // full acknowledge sequence with expected level code and vector
    task automatic take_irq(input string tag, input int exp_code, input int vec);
        insn_boundary = 1'b1;
        tick();
        insn_boundary = 1'b0;
        check({tag, " ack_valid"}, int'(ack_valid), 1);
        check({tag, " ack_code"}, int'(ack_code), exp_code);
        vec_in    = VW'(vec);
        vec_valid = 1'b1;
        tick();
        vec_valid = 1'b0;
        check({tag, " take"}, int'(take), 1);
        check({tag, " addr"}, int'(handler_addr), int'(table_base) + vec * 4);
        tick();
        check({tag, " take end"}, int'(take), 0);
    endtask

    task automatic expect_no_ack(input string tag);
        insn_boundary = 1'b1;
        tick();
        insn_boundary = 1'b0;
        check({tag, " no ack"}, int'(ack_valid), 0);
    endtask

    task automatic do_return();
        irq_return = 1'b1;
        tick();
        irq_return = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        settle(3);
        rst_n = 1'b1;
        tick();
        // R11 reset state
        check("R11 ack_valid", int'(ack_valid), 0);
        check("R11 take", int'(take), 0);
        check("R11 stk_ovf", int'(stk_ovf), 0);
        check("R11 stk_unf", int'(stk_unf), 0);

        // R10 underflow: return with nothing saved
        do_return();
        check("R10 underflow flag", int'(stk_unf), 1);
        // R3 idle level still accepts the least urgent line
        irq_req = 4'b1000;
        settle(4);
        take_irq("R3 idle accepts", 4, 9);
        irq_req = '0;
        do_return();

        // R1/R8 exhaustive sweep of request masks
        for (int m = 1; m < 16; m++) begin
            int low;
            low = 0;
            for (int b = 3; b >= 0; b--) if (m[b]) low = b;
            table_base = AW'(16'h1000 + m * 16'h0100);
            irq_req    = N'(m);
            settle(4);
            take_irq($sformatf("R1 mask %0d", m), low + 1, 15 - m);
            irq_req = '0;
            do_return();
        end
        table_base = 16'h4000;

        // R6 held request without boundary is never acknowledged
        irq_req = 4'b0001;
        settle(8);
        check("R6 no boundary", int'(ack_valid), 0);
        take_irq("R6 boundary", 1, 3);
        irq_req = '0;
        do_return();
        settle(3);

        // R7 two-edge synchronizer latency
        irq_req       = 4'b0100;
        insn_boundary = 1'b1;
        tick();
        check("R7 edge1", int'(ack_valid), 0);
        tick();
        check("R7 edge2", int'(ack_valid), 0);
        tick();
        insn_boundary = 1'b0;
        check("R7 edge3 ack", int'(ack_valid), 1);
        check("R7 edge3 code", int'(ack_code), 3);
        vec_in    = 4'd5;
        vec_valid = 1'b1;
        tick();
        vec_valid = 1'b0;
        check("R9 take", int'(take), 1);
        tick();
        check("R9 take one cycle", int'(take), 0);

        // R3 masking while level 3 is in service
        expect_no_ack("R3 equal level");
        irq_req = 4'b1100;
        settle(4);
        expect_no_ack("R3 lower level");
        irq_req = 4'b1101;
        settle(4);
        take_irq("R3 nested higher", 1, 7);
        irq_req = 4'b1000;
        settle(2);
        do_return();
        expect_no_ack("R4 back to level 3");
        do_return();
        take_irq("R4 pending served", 4, 2);
        irq_req = '0;
        do_return();

        // R5 non-maskable nests on top of line 0 and on itself
        irq_req = 4'b0001;
        settle(4);
        take_irq("R5 base line0", 1, 1);
        irq_req = '0;
        nmi_req = 1'b1;
        settle(4);
        take_irq("R5 nmi over line0", 0, 12);
        nmi_req = 1'b0;
        settle(3);
        nmi_req = 1'b1;
        settle(4);
        take_irq("R5 nmi over nmi", 0, 13);
        nmi_req = 1'b0;
        settle(3);

        // R10 overflow: three entries saved, fill to DEP then one more
        for (int k = 0; k < 4; k++) begin
            nmi_req = 1'b1;
            settle(4);
            take_irq("R10 nmi push", 0, k);
            nmi_req = 1'b0;
            settle(3);
            check($sformatf("R10 overflow after push %0d", k), int'(stk_ovf), (k == 3) ? 1 : 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule